// File: doc/BRIEF.md
# Branch and Loop Condition Evaluator

This block decides, for one conditional control-transfer instruction at a time, whether the branch is taken. It takes the five status flags, the loop count register value, a 4-bit condition code and a 3-bit instruction class. It returns a taken decision, the count value to write back, and a write enable for that count. The status flags are only read and never produced. The branch target and instruction fetch are handled elsewhere.

Conditional jumps evaluate one of eight base predicates selected by the upper three bits of the condition code. The lowest bit of the code inverts the result. The count-zero jump looks only at the count. The three loop classes first decrement the count and then test the new value. Two of them also require a particular zero-flag state. All outputs are registered, so each decision appears one clock after its inputs are presented.

Top module: `bce_eval`

## Requirements
- R1: While reset is asserted, and after it, until the first clock edge with reset released, taken_o, count_we_o and count_o are all zero.
- R2: In the conditional-jump class (class 0), the condition code bits [3:1] select a base predicate: 0 overflow, 1 carry, 2 zero, 3 carry or zero, 4 sign, 5 parity, 6 sign differs from overflow, 7 zero or sign differs from overflow. A one in bit [0] inverts that predicate. The flag bus layout is bit 4 OF, bit 3 SF, bit 2 ZF, bit 1 PF, bit 0 CF.
- R3: The unsigned comparisons use these codes. Below (0x2) is taken when CF=1. Above-or-equal (0x3) is taken when CF=0. Below-or-equal (0x6) is taken when CF or ZF is 1. Above (0x7) is taken only when both CF and ZF are 0.
- R4: The signed comparisons use these codes. Less (0xC) is taken when SF differs from OF. Greater-or-equal (0xD) is taken when SF equals OF. Less-or-equal (0xE) is taken when ZF=1 or SF differs from OF. Greater (0xF) is taken when ZF=0 and SF equals OF.
- R5: The count-zero jump (class 1) is taken exactly when count_i is zero. The condition code and the flags have no effect on it, and it writes no count.
- R6: LOOP (class 2) outputs count_i minus one, wrapping 0 to all ones, with count_we_o set. It is taken exactly when that new value is nonzero.
- R7: Loop-while-zero (class 3) decrements like R6 and is taken only when the new count is nonzero and ZF=1.
- R8: Loop-while-not-zero (class 4) decrements like R6 and is taken only when the new count is nonzero and ZF=0.
- R9: count_we_o is set only for classes 2, 3 and 4. In every other case count_o equals count_i. Classes 5 to 7 are reserved and are never taken.
- R10: Each result appears on the outputs after the first rising clock edge that samples its inputs, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| flags_i | input | 5 | Status flags {OF, SF, ZF, PF, CF} |
| count_i | input | CNT_W | Loop count value on entry |
| cond_i | input | 4 | Condition code for class 0 |
| class_i | input | 3 | Instruction class select |
| taken_o | output | 1 | Branch or loop taken |
| count_o | output | CNT_W | Count value to write back |
| count_we_o | output | 1 | Count write enable |

## Verification
Some relations are checked by assertions on every cycle against the inputs of the previous cycle. These are: the write enable appears only for loop classes, the written count is always the input minus one, a taken loop never leaves a zero count, the zero-flag condition of the two conditional loops, and the count-zero jump behaviour. The predicate mapping of all sixteen condition codes is shown only by the bench. It sweeps every code against all 32 flag combinations and adds a table of named cases. The same holds for the wrap from zero, the count-of-one exit, reset behaviour and the one-cycle latency, which only directed scenarios show.

// File: rtl/bce_pkg.sv
package bce_pkg;

   localparam int unsigned COND_W  = 4;
   localparam int unsigned CLASS_W = 3;
   localparam int unsigned FLAG_W  = 5;
   localparam int unsigned NPRED   = 1 << (COND_W - 1);

   typedef enum logic [CLASS_W-1:0] {
      CLS_JCC    = 3'd0,
      CLS_JCXZ   = 3'd1,
      CLS_LOOP   = 3'd2,
      CLS_LOOPZ  = 3'd3,
      CLS_LOOPNZ = 3'd4
   } br_class_e;

   typedef struct packed {
      logic ovf;
      logic sgn;
      logic zro;
      logic par;
      logic cry;
   } flags_t;

   typedef enum logic [COND_W-2:0] {
      P_OVF    = 3'd0,
      P_CRY    = 3'd1,
      P_ZRO    = 3'd2,
      P_BEQ    = 3'd3,
      P_SGN    = 3'd4,
      P_PAR    = 3'd5,
      P_LESS   = 3'd6,
      P_LEQ    = 3'd7
   } pred_sel_e;

endpackage

// File: rtl/bce_cond_pred.sv
module bce_cond_pred
   import bce_pkg::*;
(
   input  flags_t              flg_i,
   input  logic [COND_W-1:0]   cond_i,
   output logic                hit_o
);

   logic [NPRED-1:0] base;
   logic             sign_ne_ovf;

   assign sign_ne_ovf = flg_i.sgn ^ flg_i.ovf;

   // one base predicate per code pair; the low code bit flips polarity
   generate
      for (genvar k = 0; k < NPRED; k++) begin : g_pred
         always_comb begin
            case (pred_sel_e'(k))
               P_OVF:   base[k] = flg_i.ovf;
               P_CRY:   base[k] = flg_i.cry;
               P_ZRO:   base[k] = flg_i.zro;
               P_BEQ:   base[k] = flg_i.cry | flg_i.zro;
               P_SGN:   base[k] = flg_i.sgn;
               P_PAR:   base[k] = flg_i.par;
               P_LESS:  base[k] = sign_ne_ovf;
               default: base[k] = flg_i.zro | sign_ne_ovf;
            endcase
         end
      end
   endgenerate

   assign hit_o = base[cond_i[COND_W-1:1]] ^ cond_i[0];

endmodule

// File: rtl/bce_loop_ctr.sv
module bce_loop_ctr #(
   parameter int unsigned CNT_W = 16
) (
   input  logic [CNT_W-1:0] count_i,
   output logic [CNT_W-1:0] next_o,
   output logic             next_nz_o,
   output logic             entry_zero_o
);

   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   // decrement first, then test the decremented value
   assign next_o       = count_i - ONE;
   assign next_nz_o    = |next_o;
   assign entry_zero_o = ~|count_i;

endmodule

// File: rtl/bce_eval.sv
module bce_eval
   import bce_pkg::*;
#(
   parameter int unsigned CNT_W   = 16,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [4:0]          flags_i,
   input  logic [CNT_W-1:0]    count_i,
   input  logic [3:0]          cond_i,
   input  logic [2:0]          class_i,
   output logic                taken_o,
   output logic [CNT_W-1:0]    count_o,
   output logic                count_we_o
);

   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("bce_eval: CNT_W must be at least 2");
      end
      if (FLAG_W != 5) begin : g_bad_flags
         $error("bce_eval: flag bus must carry five flags");
      end
   endgenerate

   flags_t           flg;
   br_class_e        cls;
   logic             pred_hit;
   logic [CNT_W-1:0] cnt_dec;
   logic             dec_nz;
   logic             in_zero;

   assign flg = flags_t'(flags_i);
   assign cls = br_class_e'(class_i);

   bce_cond_pred u_pred (
      .flg_i  (flg),
      .cond_i (cond_i),
      .hit_o  (pred_hit)
   );

   bce_loop_ctr #(.CNT_W(CNT_W)) u_loop (
      .count_i      (count_i),
      .next_o       (cnt_dec),
      .next_nz_o    (dec_nz),
      .entry_zero_o (in_zero)
   );

   logic             taken_d;
   logic             we_d;
   logic [CNT_W-1:0] cnt_d;

   always_comb begin
      taken_d = 1'b0;
      we_d    = 1'b0;
      cnt_d   = count_i;
      case (cls)
         CLS_JCC:    taken_d = pred_hit;
         CLS_JCXZ:   taken_d = in_zero;
         CLS_LOOP: begin
            we_d    = 1'b1;
            cnt_d   = cnt_dec;
            taken_d = dec_nz;
         end
         CLS_LOOPZ: begin
            we_d    = 1'b1;
            cnt_d   = cnt_dec;
            taken_d = dec_nz & flg.zro;
         end
         CLS_LOOPNZ: begin
            we_d    = 1'b1;
            cnt_d   = cnt_dec;
            taken_d = dec_nz & ~flg.zro;
         end
         default: ;
      endcase
   end

   generate
      if (OUT_REG) begin : g_reg
         logic live_q;

         always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
               taken_o    <= 1'b0;
               count_we_o <= 1'b0;
               count_o    <= '0;
               live_q     <= 1'b0;
            end else begin
               taken_o    <= taken_d;
               count_we_o <= we_d;
               count_o    <= cnt_d;
               live_q     <= 1'b1;
            end
         end

         assert_we_loop_only_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            live_q && count_we_o |->
               ($past(class_i) == 3'd2 || $past(class_i) == 3'd3 || $past(class_i) == 3'd4));

         assert_count_pass_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            live_q && !count_we_o |-> count_o == $past(count_i));

         assert_loop_dec_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            live_q && count_we_o |-> count_o == ($past(count_i) - ONE));

         assert_loop_nonzero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            live_q && count_we_o && taken_o |-> count_o != '0);

         assert_loopz_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            live_q && $past(class_i) == 3'd3 && taken_o |-> $past(flags_i[2]));

         assert_loopnz_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            live_q && $past(class_i) == 3'd4 && taken_o |-> !$past(flags_i[2]));

         assert_cxz_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            live_q && $past(class_i) == 3'd1 |->
               (taken_o == ($past(count_i) == '0)) && !count_we_o);

         assert_reserved_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            live_q && $past(class_i) > 3'd4 |-> !taken_o && !count_we_o);
      end else begin : g_comb
         assign taken_o    = taken_d;
         assign count_we_o = we_d;
         assign count_o    = cnt_d;

         assert_loop_nonzero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            count_we_o && taken_o |-> count_o != '0);
      end
   endgenerate

endmodule

// File: tb/bce_eval_tb.sv
module bce_eval_tb_top;

   localparam int CNT_W = 16;
   localparam int NVEC  = 26;

   // {req[3:0], cls[2:0], cond[3:0], flags{O,S,Z,P,C}[4:0], cnt[15:0], taken, we, ecnt[15:0]}
   localparam logic [49:0] VEC [NVEC] = '{
      {4'd2, 3'd0, 4'h0, 5'b10000, 16'h1234, 1'b1, 1'b0, 16'h1234}, // R2 overflow true
      {4'd2, 3'd0, 4'h1, 5'b10000, 16'h1234, 1'b0, 1'b0, 16'h1234}, // R2 overflow inverted
      {4'd3, 3'd0, 4'h2, 5'b00001, 16'h0001, 1'b1, 1'b0, 16'h0001}, // R3 below
      {4'd3, 3'd0, 4'h3, 5'b00001, 16'h0001, 1'b0, 1'b0, 16'h0001}, // R3 above-or-equal
      {4'd3, 3'd0, 4'h7, 5'b00000, 16'h0002, 1'b1, 1'b0, 16'h0002}, // R3 above
      {4'd3, 3'd0, 4'h7, 5'b00100, 16'h0002, 1'b0, 1'b0, 16'h0002}, // R3 above blocked by ZF
      {4'd3, 3'd0, 4'h6, 5'b00100, 16'h0003, 1'b1, 1'b0, 16'h0003}, // R3 below-or-equal
      {4'd4, 3'd0, 4'hC, 5'b01000, 16'h0004, 1'b1, 1'b0, 16'h0004}, // R4 less
      {4'd4, 3'd0, 4'hD, 5'b11000, 16'h0004, 1'b1, 1'b0, 16'h0004}, // R4 greater-or-equal
      {4'd4, 3'd0, 4'hF, 5'b11100, 16'h0005, 1'b0, 1'b0, 16'h0005}, // R4 greater blocked by ZF
      {4'd4, 3'd0, 4'hF, 5'b00000, 16'h0005, 1'b1, 1'b0, 16'h0005}, // R4 greater
      {4'd4, 3'd0, 4'hE, 5'b10000, 16'h0006, 1'b1, 1'b0, 16'h0006}, // R4 less-or-equal
      {4'd2, 3'd0, 4'hA, 5'b00010, 16'h0007, 1'b1, 1'b0, 16'h0007}, // R2 parity
      {4'd2, 3'd0, 4'hB, 5'b00010, 16'h0007, 1'b0, 1'b0, 16'h0007}, // R2 no parity
      {4'd2, 3'd0, 4'h4, 5'b00100, 16'h0008, 1'b1, 1'b0, 16'h0008}, // R2 zero
      {4'd5, 3'd1, 4'h3, 5'b11111, 16'h0000, 1'b1, 1'b0, 16'h0000}, // R5 count zero
      {4'd5, 3'd1, 4'h0, 5'b10000, 16'h0005, 1'b0, 1'b0, 16'h0005}, // R5 count nonzero
      {4'd6, 3'd2, 4'h0, 5'b00000, 16'h0000, 1'b1, 1'b1, 16'hFFFF}, // R6 wrap from zero
      {4'd6, 3'd2, 4'h0, 5'b11111, 16'h0001, 1'b0, 1'b1, 16'h0000}, // R6 last pass
      {4'd6, 3'd2, 4'h0, 5'b00000, 16'h000A, 1'b1, 1'b1, 16'h0009}, // R6 mid loop
      {4'd7, 3'd3, 4'h0, 5'b00100, 16'h0003, 1'b1, 1'b1, 16'h0002}, // R7 ZF set
      {4'd7, 3'd3, 4'h0, 5'b00000, 16'h0003, 1'b0, 1'b1, 16'h0002}, // R7 ZF clear
      {4'd7, 3'd3, 4'h0, 5'b00100, 16'h0001, 1'b0, 1'b1, 16'h0000}, // R7 count ends
      {4'd8, 3'd4, 4'h0, 5'b00000, 16'h0003, 1'b1, 1'b1, 16'h0002}, // R8 ZF clear
      {4'd8, 3'd4, 4'h0, 5'b00100, 16'h0003, 1'b0, 1'b1, 16'h0002}, // R8 ZF set
      {4'd9, 3'd7, 4'h0, 5'b11111, 16'h0055, 1'b0, 1'b0, 16'h0055}  // R9 reserved class
   };

   logic             clk_i = 1'b0;
   logic             rst_ni = 1'b0;
   logic [4:0]       flags_i = '0;
   logic [CNT_W-1:0] count_i = '0;
   logic [3:0]       cond_i = '0;
   logic [2:0]       class_i = '0;
   logic             taken_o;
   logic [CNT_W-1:0] count_o;
   logic             count_we_o;

   int  n_checks = 0;
   int  n_errors = 0;
   bit  finished = 1'b0;

   always #10 clk_i = ~clk_i;

   bce_eval #(.CNT_W(CNT_W)) dut_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .flags_i    (flags_i),
      .count_i    (count_i),
      .cond_i     (cond_i),
      .class_i    (class_i),
      .taken_o    (taken_o),
      .count_o    (count_o),
      .count_we_o (count_we_o)
   );

   task automatic check(input int req, input logic t, input logic w, input logic [CNT_W-1:0] c);
      n_checks++;
      if (taken_o !== t || count_we_o !== w || count_o !== c) begin
         n_errors++;
         $display("FAIL R%0d: got taken=%b we=%b count=%h, expected taken=%b we=%b count=%h",
                  req, taken_o, count_we_o, count_o, t, w, c);
      end
   endtask

   task automatic apply(input logic [2:0] cl, input logic [3:0] cd,
                        input logic [4:0] fl, input logic [CNT_W-1:0] cn);
      class_i = cl; cond_i = cd; flags_i = fl; count_i = cn;
      @(posedge clk_i);
      @(negedge clk_i);
   endtask

   // predicate model written from R2
   function automatic logic model_pred(input logic [3:0] cd, input logic [4:0] fl);
      logic o, s, z, p, c, b;
      {o, s, z, p, c} = fl;
      case (cd[3:1])
         3'd0: b = o;
         3'd1: b = c;
         3'd2: b = z;
         3'd3: b = c | z;
         3'd4: b = s;
         3'd5: b = p;
         3'd6: b = s ^ o;
         default: b = z | (s ^ o);
      endcase
      return b ^ cd[0];
   endfunction

   initial begin
      repeat (150000) @(posedge clk_i);
      if (!finished) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      // R1: outputs are zero during reset, even with loop stimulus applied
      class_i = 3'd2; count_i = 16'h0000; flags_i = 5'b11111;
      repeat (3) @(posedge clk_i);
      @(negedge clk_i);
      check(1, 1'b0, 1'b0, 16'h0000); // R1
      rst_ni = 1'b1;
      class_i = 3'd0; cond_i = 4'h0; flags_i = 5'b0; count_i = 16'h0;
      #1 check(1, 1'b0, 1'b0, 16'h0000); // R1 before first released edge

      // table walk
      for (int i = 0; i < NVEC; i++) begin
         logic [49:0] v;
         v = VEC[i];
         apply(v[45:43], v[42:39], v[38:34], v[33:18]);
         check(int'(v[49:46]), v[17], v[16], v[15:0]);
      end

      // R2: every condition code against every flag combination
      for (int cd = 0; cd < 16; cd++) begin
         for (int fl = 0; fl < 32; fl++) begin
            apply(3'd0, 4'(cd), 5'(fl), 16'h00A5);
            check(2, model_pred(4'(cd), 5'(fl)), 1'b0, 16'h00A5); // R2
         end
      end

      // R5: count-zero jump ignores every condition code and flag value
      for (int cd = 0; cd < 16; cd++) begin
         apply(3'd1, 4'(cd), 5'(cd * 2 + 1), 16'h0000);
         check(5, 1'b1, 1'b0, 16'h0000); // R5
      end

      // R10: new inputs do not reach the outputs before the sampling edge
      apply(3'd2, 4'h0, 5'b0, 16'h0100);
      check(10, 1'b1, 1'b1, 16'h00FF); // R10 / R6
      class_i = 3'd1; count_i = 16'h0000;
      #2 check(10, 1'b1, 1'b1, 16'h00FF); // R10 still old value
      @(posedge clk_i);
      @(negedge clk_i);
      check(10, 1'b1, 1'b0, 16'h0000); // R10 new value after one edge

      // R6: full-width count from all ones
      apply(3'd2, 4'h0, 5'b0, 16'hFFFF);
      check(6, 1'b1, 1'b1, 16'hFFFE); // R6

      // R1: reset in mid-run clears the outputs
      apply(3'd3, 4'h0, 5'b00100, 16'h0009);
      rst_ni = 1'b0;
      @(posedge clk_i);
      @(negedge clk_i);
      check(1, 1'b0, 1'b0, 16'h0000); // R1
      rst_ni = 1'b1;
      apply(3'd4, 4'h0, 5'b00000, 16'h0009);
      check(8, 1'b1, 1'b1, 16'h0008); // R8

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule